// File: doc/BRIEF.md
# Delayed-Reference Bit Match Counter

This block measures link quality by comparing a recovered NRZ bit stream with the transmitted NRZ stream. The transmitted bits pass through a delay line whose length, in bit periods, comes from an 8-bit switch value. An operator changes that value until the delayed copy lines up with what comes back from the channel.

Every bit period is marked by a single-cycle bit-enable pulse. The block counts how many received bits agree with the delayed reference over consecutive bursts of exactly 1000 bit periods. At the end of each burst it publishes the tally in binary and as four BCD digits for a seven-segment display. The error rate in percent is then (1000 − tally)/10.

A synchronisation lamp lights while the most recent burst shows at least 990 agreeing bits. The clock is nominally 100 MHz. The bit rate is at most one tenth of the clock, and reset is asynchronous and active-high.

Top module: `bit_match_counter`

## Requirements
- R1: While reset is asserted and after it is released, until the first burst completes, match_bin is 0, match_bcd is 16'h0000 and sync_led is 0.
- R2: For a delay setting D (0 to 255) on dly_sel, the reference for the k-th bit-enable after reset is the tx_nrz value sampled at bit-enable k−D. For k < D the reference is 0. D = 0 compares rx_nrz against the current tx_nrz.
- R3: tx_nrz, rx_nrz and dly_sel are sampled only in clock cycles where bit_en is high. Activity on them in other cycles changes neither the outputs nor any later tally.
- R4: A burst is exactly 1000 bit-enable pulses. On the clock edge of the 1000th pulse, match_bin takes the number of those 1000 pulses where rx_nrz equalled the reference, that last pulse included. The next burst starts counting from zero.
- R5: Between burst ends, match_bin, match_bcd and sync_led hold their values.
- R6: match_bcd carries match_bin as four BCD digits: thousands in bits [15:12], hundreds in [11:8], tens in [7:4] and units in [3:0]. It changes in the same cycle as match_bin.
- R7: sync_led is 1 exactly when the last completed burst counted 990 or more matches. At 989 or fewer it is 0.
- R8: A burst with every bit matching reports 1000 (match_bcd 16'h1000) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe marking each bit period |
| tx_nrz | input | 1 | Transmitted NRZ data |
| rx_nrz | input | 1 | Recovered NRZ data |
| dly_sel | input | 8 | Reference delay in bit periods |
| match_bcd | output | 16 | Last burst tally, four BCD digits |
| match_bin | output | 10 | Last burst tally in binary |
| sync_led | output | 1 | High while the last tally is at least 990 |

## Verification
All state is hidden until a burst ends, so a wrong delay tap, a dropped count or a misplaced burst boundary only shows up at the port about 1000 bit periods later, as a tally that differs from the expected one. The bench therefore predicts each burst's tally independently, bit by bit, and compares it when the burst closes. It uses aligned streams with chosen error counts either side of the 990 threshold, the delay extremes 0 and 255, and a deliberately wrong delay. An unstable output between bursts, or a BCD value that does not match the binary one, shows up at once in the cycle after it happens.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
   // per-bit observation handed from the comparator to the tally
   typedef struct packed {
      logic strobe;   // a bit period is being sampled this cycle
      logic agree;    // received bit equals the delayed reference
   } bit_obs_t;
endpackage

// File: rtl/bmc_delay_line.sv
module bmc_delay_line
   import bmc_pkg::*;
#(
   parameter int SEL_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_en,
   input  logic             tx_nrz,
   input  logic             rx_nrz,
   input  logic [SEL_W-1:0] dly_sel,
   output bit_obs_t         obs
);
   localparam int STAGES = (1 << SEL_W) - 1;

   logic [STAGES-1:0] hist;
   logic [STAGES:0]   taps;
   logic              ref_bit;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         hist <= '0;
      else if (bit_en)
         hist <= {hist[STAGES-2:0], tx_nrz};
   end

   // tap 0 is the live transmit bit, tap d the bit from d periods ago
   assign taps    = {hist, tx_nrz};
   assign ref_bit = taps[dly_sel];

   assign obs.strobe = bit_en;
   assign obs.agree  = (ref_bit == rx_nrz);
endmodule

// File: rtl/bmc_burst_tally.sv
module bmc_burst_tally
   import bmc_pkg::*;
#(
   parameter int BURST    = 1000,
   parameter int CNT_W    = 10,
   parameter int SYNC_MIN = 990
) (
   input  logic             clk,
   input  logic             rst,
   input  bit_obs_t         obs,
   output logic [CNT_W-1:0] tally,
   output logic             in_sync
);
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] run;
   logic [CNT_W-1:0] run_nx;
   logic             last;

   assign run_nx = run + {{(CNT_W-1){1'b0}}, obs.agree};
   assign last   = (pos == CNT_W'(BURST - 1));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pos     <= '0;
         run     <= '0;
         tally   <= '0;
         in_sync <= 1'b0;
      end else if (obs.strobe) begin
         if (last) begin
            pos     <= '0;
            run     <= '0;
            tally   <= run_nx;
            in_sync <= (run_nx >= CNT_W'(SYNC_MIN));
         end else begin
            pos <= pos + 1'b1;
            run <= run_nx;
         end
      end
   end
endmodule

// File: rtl/bmc_bin2bcd.sv
module bmc_bin2bcd #(
   parameter int BIN_W  = 10,
   parameter int DIGITS = 4
) (
   input  logic [BIN_W-1:0]    bin,
   output logic [4*DIGITS-1:0] bcd
);
   logic [4*DIGITS-1:0] acc;

   // shift-and-add-three conversion, unrolled over the input bits
   always_comb begin
      acc = '0;
      for (int i = BIN_W - 1; i >= 0; i--) begin
         for (int d = 0; d < DIGITS; d++) begin
            if (acc[4*d +: 4] > 4'd4)
               acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
         end
         acc = {acc[4*DIGITS-2:0], bin[i]};
      end
      bcd = acc;
   end
endmodule

// File: rtl/bit_match_counter.sv
module bit_match_counter
   import bmc_pkg::*;
#(
   parameter int  SEL_W      = 8,
   parameter int  BURST      = 1000,
   parameter int  SYNC_MIN   = 990,
   parameter int  BCD_DIGITS = 4,
   localparam int CNT_W      = $clog2(BURST + 1)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    bit_en,
   input  logic                    tx_nrz,
   input  logic                    rx_nrz,
   input  logic [SEL_W-1:0]        dly_sel,
   output logic [4*BCD_DIGITS-1:0] match_bcd,
   output logic [CNT_W-1:0]        match_bin,
   output logic                    sync_led
);
   generate
      if (SEL_W < 2) begin : g_bad_sel
         $error("SEL_W must be at least 2");
      end
      if (BURST < 2) begin : g_bad_burst
         $error("BURST must be at least 2");
      end
      if (SYNC_MIN > BURST) begin : g_bad_sync
         $error("SYNC_MIN cannot exceed BURST");
      end
      if (10 ** BCD_DIGITS <= BURST) begin : g_bad_digits
         $error("BCD_DIGITS too small for BURST");
      end
   endgenerate

   bit_obs_t obs;

   bmc_delay_line #(.SEL_W(SEL_W)) u_dly (
      .clk     (clk),
      .rst     (rst),
      .bit_en  (bit_en),
      .tx_nrz  (tx_nrz),
      .rx_nrz  (rx_nrz),
      .dly_sel (dly_sel),
      .obs     (obs)
   );

   bmc_burst_tally #(
      .BURST    (BURST),
      .CNT_W    (CNT_W),
      .SYNC_MIN (SYNC_MIN)
   ) u_tally (
      .clk     (clk),
      .rst     (rst),
      .obs     (obs),
      .tally   (match_bin),
      .in_sync (sync_led)
   );

   bmc_bin2bcd #(.BIN_W(CNT_W), .DIGITS(BCD_DIGITS)) u_bcd (
      .bin (match_bin),
      .bcd (match_bcd)
   );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
   parameter int BURST      = 1000,
   parameter int SYNC_MIN   = 990,
   parameter int BCD_DIGITS = 4,
   parameter int CNT_W      = 10
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    bit_en,
   input logic [4*BCD_DIGITS-1:0] match_bcd,
   input logic [CNT_W-1:0]        match_bin,
   input logic                    sync_led
);
   int bcd_val;

   always_comb begin
      bcd_val = 0;
      for (int d = BCD_DIGITS - 1; d >= 0; d--)
         bcd_val = bcd_val * 10 + int'(match_bcd[4*d +: 4]);
   end

   // R4: a burst never reports more matches than it has bits
   assert_bin_range_R4: assert property (@(posedge clk) disable iff (rst)
      int'(match_bin) <= BURST);

   // R6: the decimal digits agree with the binary tally
   assert_bcd_value_R6: assert property (@(posedge clk) disable iff (rst)
      bcd_val == int'(match_bin));

   genvar g;
   generate
      for (g = 0; g < BCD_DIGITS; g++) begin : g_dig
         assert_bcd_digit_R6: assert property (@(posedge clk) disable iff (rst)
            match_bcd[4*g +: 4] <= 4'd9);
      end
   endgenerate

   // R5: the tally only moves on a bit-enable cycle
   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(match_bin));

   // R3: the lamp ignores cycles without bit-enable
   assert_lamp_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(sync_led));

   // R7: lamp follows the threshold on the published tally
   assert_sync_R7: assert property (@(posedge clk) disable iff (rst)
      sync_led == (int'(match_bin) >= SYNC_MIN));
endmodule

bind bit_match_counter bmc_checker #(
   .BURST      (BURST),
   .SYNC_MIN   (SYNC_MIN),
   .BCD_DIGITS (BCD_DIGITS),
   .CNT_W      (CNT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bit_en    (bit_en),
   .match_bcd (match_bcd),
   .match_bin (match_bin),
   .sync_led  (sync_led)
);

// File: tb/bit_match_counter_test.sv
module bit_match_counter_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bit_en = 1'b0;
   logic        tx_nrz = 1'b0;
   logic        rx_nrz = 1'b0;
   logic [7:0]  dly_sel = 8'd0;
   logic [15:0] match_bcd;
   logic [9:0]  match_bin;
   logic        sync_led;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   bit       hist [0:1023];
   int       k = 0;           // bit index since reset
   int       pos = 0;         // bit within burst
   int       hits = 0;
   bit [15:0] lfsr = 16'hACE1;
   int       exp_q[$];
   int       last_exp = 0;

   always #4 clk = ~clk;

   bit_match_counter uut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .tx_nrz(tx_nrz),
      .rx_nrz(rx_nrz), .dly_sel(dly_sel), .match_bcd(match_bcd),
      .match_bin(match_bin), .sync_led(sync_led)
   );

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int to_bcd(int v);
      return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 +
             ((v / 10) % 10) * 16 + (v % 10);
   endfunction

   task automatic check_outputs(string req, int exp);
      check(req, int'(match_bin), exp, "match_bin");
      check("R6", int'(match_bcd), to_bcd(exp), "match_bcd");
      check("R7", int'(sync_led), (exp >= 990) ? 1 : 0, "sync_led");
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   function automatic bit past_bit(int idx);
      return (idx >= 0) ? hist[idx % 1024] : 1'b0;
   endfunction

   // driver: one bit-enable, then one idle cycle with random noise (R3)
   task automatic drive_bits(int n, int dly, int align, int nerr);
      for (int i = 0; i < n; i++) begin
         bit t, r, rf;
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         t = lfsr[0];
         hist[k % 1024] = t;
         rf = past_bit(k - dly);                 // R2 reference
         r  = past_bit(k - align) ^ (pos < nerr);
         bit_en  = 1'b1;
         tx_nrz  = t;
         rx_nrz  = r;
         dly_sel = 8'(dly);
         if (r == rf) hits++;
         k++;
         pos++;
         @(posedge clk);
         if (pos == 1000) begin                  // R4 burst boundary
            exp_q.push_back(hits);
            pos  = 0;
            hits = 0;
         end
         @(negedge clk);
         bit_en  = 1'b0;
         tx_nrz  = lfsr[3];
         rx_nrz  = lfsr[7];
         dly_sel = lfsr[15:8];
      end
   endtask

   // monitor: compare each published tally against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            last_exp = exp_q.pop_front();
            check_outputs("R4", last_exp);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check_outputs("R1", 0);                    // during reset
      rst = 1'b0;
      @(negedge clk);
      check_outputs("R1", 0);
      drive_bits(1000, 5, 5, 0);                 // R8 full match, R2
      drive_bits(1000, 5, 5, 10);                // R7 at 990
      drive_bits(1000, 5, 5, 11);                // R7 at 989
      drive_bits(1000, 0, 0, 37);                // R2 zero delay
      drive_bits(1000, 255, 255, 3);             // R2 longest delay
      drive_bits(1000, 7, 5, 0);                 // misaligned
      drive_bits(400, 5, 5, 0);
      repeat (2) @(negedge clk);
      check_outputs("R5", last_exp);             // mid-burst hold
      rst = 1'b1;                                // reset mid-burst
      #1;
      check_outputs("R1", 0);
      for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
      k = 0; pos = 0; hits = 0;
      @(negedge clk);
      rst = 1'b0;
      drive_bits(1000, 5, 5, 1);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0 ? "R4" : "R4", exp_q.size(), 0, "pending");
      summary();
   end
endmodule